// File: doc/BRIEF.md
# Lockable PWM Channel

This block produces one pulse-width-modulated output from a small register file on a single-cycle bus. A free-running counter counts input clock cycles from zero up to the period minus one and then wraps. In each period the output first holds its active level for the duty count and then its inactive level for the rest of the period. Two control bits choose those two levels independently, so one write can select normal or inverted polarity.

Software writes period, duty and polarity into staged registers. The waveform only uses a second, active copy of them. The active copy is reloaded from the staged copy at a period rollover, so the running waveform never shows a half-written setting. A lock bit in the control register stops these reloads. Software can set the lock, rewrite every field while the old waveform keeps running, and then clear the lock. The new period, duty and polarity then start together on the next period boundary.

Top module: `lockpwm_channel`

## Requirements
- R1: After synchronous reset, every register reads zero and `pwm_out` is low.
- R2: Byte offsets select the registers: 0x0 is the counter, 0x4 the period, 0x8 the duty and 0xC the control. Writes to the counter have no effect. Period and duty read back the last value written. Control reads back bits 0, 1, 3, 4 and 6 as written. Bit 5 and all other bits read zero, because only left-aligned output exists.
- R3: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the counter reads zero and `pwm_out` holds the inactive level.
- R4: While running with a nonzero period P, the counter register returns the live count. The count rises by one each cycle from 0 to P-1 and then returns to 0.
- R5: The output is left-aligned. While the count is below the duty, it drives the active level (control bit 3). Otherwise it drives the inactive level (control bit 4). With bit 3 = 1 and bit 4 = 0 the output is high for the duty and then low. With bit 3 = 0 and bit 4 = 1 it is the opposite.
- R6: A duty equal to or above the period gives a constant active level. A duty of zero gives a constant inactive level. A period of zero holds the counter at zero and the output at the inactive level.
- R7: While running and unlocked, a newly written period, duty or polarity takes effect only when the count wraps from P-1 to 0, never in the middle of a period.
- R8: While control bit 6 (lock) is 1, the active period, duty and polarity stay unchanged across any number of rollovers and any writes.
- R9: A single control write can clear the lock and change the polarity bits. The staged period, duty and new polarity then all take effect together at the start of the next period.
- R10: While the channel is stopped and unlocked, the active settings follow the staged ones, so enabling starts directly with the written period, duty and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counts are in cycles of this clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read, when selected |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 1 | PWM pin output |

## Verification
On every cycle the assertions check these rules:
- a stopped channel drives its inactive level and clears its count;
- the count stays below the active period and steps by one between wraps;
- the active settings stay unchanged inside a period and for as long as the lock is set;
- a duty at or above the period forces the active level.

The bench compares a behavioural model on every clock. Its scenarios show what the assertions cannot:
- register readback and the ignored counter writes;
- the duty share over whole periods for both polarities;
- the combined release of lock and polarity at one boundary;
- enabling a stopped channel with freshly written values.

// File: rtl/lockpwm_pkg.sv
package lockpwm_pkg;

    localparam int CNT_W = 32;

    // register byte offsets
    localparam int OFS_COUNT  = 'h0;
    localparam int OFS_PERIOD = 'h4;
    localparam int OFS_DUTY   = 'h8;
    localparam int OFS_CTRL   = 'hC;

    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_CONT   = 1;
    localparam int B_ACTHI  = 3;
    localparam int B_IDLEHI = 4;
    localparam int B_LOCK   = 6;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             act_high;
        logic             idle_high;
    } wave_cfg_t;

    typedef struct packed {
        logic enable;
        logic cont;
        logic lock;
    } run_ctrl_t;

    function automatic logic [CNT_W-1:0] pack_ctrl(run_ctrl_t rc, logic ah, logic ih);
        logic [CNT_W-1:0] v;
        v           = '0;
        v[B_EN]     = rc.enable;
        v[B_CONT]   = rc.cont;
        v[B_ACTHI]  = ah;
        v[B_IDLEHI] = ih;
        v[B_LOCK]   = rc.lock;
        return v;
    endfunction

    function automatic logic at_rollover(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] period);
        return (period == '0) || (cnt >= period - CNT_W'(1));
    endfunction

endpackage

// File: rtl/lockpwm_regfile.sv
module lockpwm_regfile
    import lockpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    input  logic [CNT_W-1:0]     live_cnt,
    output logic [CNT_W-1:0]     bus_rdata,
    output wave_cfg_t            staged,
    output run_ctrl_t            rc
);

    logic hit_cnt, hit_per, hit_duty, hit_ctrl, wr_en;

    assign hit_cnt  = bus_addr == ADDR_W'(OFS_COUNT);
    assign hit_per  = bus_addr == ADDR_W'(OFS_PERIOD);
    assign hit_duty = bus_addr == ADDR_W'(OFS_DUTY);
    assign hit_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
    assign wr_en    = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            rc     <= '0;
        end else if (wr_en) begin
            if (hit_per)  staged.period <= bus_wdata;
            if (hit_duty) staged.duty   <= bus_wdata;
            if (hit_ctrl) begin
                rc.enable        <= bus_wdata[B_EN];
                rc.cont          <= bus_wdata[B_CONT];
                rc.lock          <= bus_wdata[B_LOCK];
                staged.act_high  <= bus_wdata[B_ACTHI];
                staged.idle_high <= bus_wdata[B_IDLEHI];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_cnt)  bus_rdata = live_cnt;
        if (hit_per)  bus_rdata = staged.period;
        if (hit_duty) bus_rdata = staged.duty;
        if (hit_ctrl) bus_rdata = pack_ctrl(rc, staged.act_high, staged.idle_high);
    end

endmodule

// File: rtl/lockpwm_timebase.sv
module lockpwm_timebase
    import lockpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wave_cfg_t        staged,
    input  run_ctrl_t        rc,
    output logic [CNT_W-1:0] cnt,
    output wave_cfg_t        active,
    output logic             running
);

    logic wrap, reload;

    assign running = rc.enable && rc.cont;
    assign wrap    = at_rollover(cnt, active.period);
    assign reload  = !rc.lock && (!running || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= '0;
        end else begin
            if (!running || wrap) cnt <= '0;
            else                  cnt <= cnt + CNT_W'(1);
            if (reload)           active <= staged;
        end
    end

endmodule

// File: rtl/lockpwm_shaper.sv
module lockpwm_shaper
    import lockpwm_pkg::*;
(
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  wave_cfg_t        active,
    output logic             pwm_out
);

    logic in_duty;

    assign in_duty = running && (active.period != '0) && (cnt < active.duty);
    assign pwm_out = in_duty ? active.act_high : active.idle_high;

endmodule

// File: rtl/lockpwm_channel.sv
module lockpwm_channel
    import lockpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);

    wave_cfg_t        stg_w;
    wave_cfg_t        act_w;
    run_ctrl_t        rc_w;
    logic [CNT_W-1:0] cnt_w;
    logic             run_w;

    lockpwm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live_cnt  (cnt_w),
        .bus_rdata (bus_rdata),
        .staged    (stg_w),
        .rc        (rc_w)
    );

    lockpwm_timebase u_tb (
        .clk     (clk),
        .rst     (rst),
        .staged  (stg_w),
        .rc      (rc_w),
        .cnt     (cnt_w),
        .active  (act_w),
        .running (run_w)
    );

    lockpwm_shaper u_shp (
        .running (run_w),
        .cnt     (cnt_w),
        .active  (act_w),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/lockpwm_checker.sv
module lockpwm_checker
    import lockpwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             lock,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] duty,
    input logic             act_high,
    input logic             idle_high,
    input logic             pwm_out
);

    // R3: stopped channel drives the inactive level
    p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
        !running |-> (pwm_out == idle_high));

    // R3: stopping clears the count on the next cycle
    p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        !running |=> (cnt == '0));

    // R4: count stays inside the active period
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (running && period != '0) |-> (cnt < period));

    // R4: count steps by one between wraps
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (running && period != '0 && cnt < period - CNT_W'(1)) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R7: no change of active settings inside a period
    p_mid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (running && period != '0 && cnt < period - CNT_W'(1))
            |=> ($stable(period) && $stable(duty) && $stable(act_high) && $stable(idle_high)));

    // R8: lock freezes the active settings
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(period) && $stable(duty) && $stable(act_high) && $stable(idle_high)));

    // R6: full duty forces the active level
    p_full_duty_r6: assert property (@(posedge clk) disable iff (rst)
        (running && period != '0 && duty >= period) |-> (pwm_out == act_high));

endmodule

bind lockpwm_channel lockpwm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .running   (run_w),
    .lock      (rc_w.lock),
    .cnt       (cnt_w),
    .period    (act_w.period),
    .duty      (act_w.duty),
    .act_high  (act_w.act_high),
    .idle_high (act_w.idle_high),
    .pwm_out   (pwm_out)
);

// File: tb/lockpwm_channel_tb.sv
`timescale 1ns/1ps
module lockpwm_channel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    lockpwm_channel #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_per_s, m_duty_s, m_per_a, m_duty_a, m_cnt;
    logic        m_en, m_cont, m_lock, m_ah_s, m_ih_s, m_ah_a, m_ih_a;
    logic        m_go, m_end;

    always @(posedge clk) begin
        if (rst) begin
            {m_per_s, m_duty_s, m_per_a, m_duty_a, m_cnt} = '0;
            {m_en, m_cont, m_lock, m_ah_s, m_ih_s, m_ah_a, m_ih_a} = '0;
        end else begin
            m_go  = m_en & m_cont;
            m_end = (m_per_a == 0) || (m_cnt + 1 >= m_per_a);
            if (!m_lock && (!m_go || m_end)) begin
                m_per_a = m_per_s; m_duty_a = m_duty_s;
                m_ah_a = m_ah_s;   m_ih_a = m_ih_s;
            end
            m_cnt = (m_go && !m_end) ? m_cnt + 1 : 32'd0;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'h4: m_per_s = bus_wdata;
                    4'h8: m_duty_s = bus_wdata;
                    4'hC: begin
                        m_en = bus_wdata[0]; m_cont = bus_wdata[1];
                        m_ah_s = bus_wdata[3]; m_ih_s = bus_wdata[4];
                        m_lock = bus_wdata[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic model_out();
        if (!(m_en && m_cont) || m_per_a == 0) return m_ih_a;
        return (m_cnt < m_duty_a) ? m_ah_a : m_ih_a;
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] a);
        case (a)
            4'h0: return m_cnt;
            4'h4: return m_per_s;
            4'h8: return m_duty_s;
            4'hC: return {25'd0, m_lock, 1'b0, m_ih_s, m_ah_s, 1'b0, m_cont, m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // every-clock waveform comparison (R5, R7, R8, R9, R10)
    always @(posedge clk) begin
        cyc++;
        #5;
        if (!rst && !done) check("R5 R7 R8 R9 R10 waveform", {31'd0, pwm_out}, {31'd0, model_out()});
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(string tag, logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        v = bus_rdata;
        check(tag, v, model_read(a));
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(int n, output int h);
        h = 0;
        repeat (n) begin
            @(posedge clk); #5;
            if (pwm_out) h++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int h;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            bus_read("R1 reset readback", 4'(i * 4), v);
            check("R1 reset value", v, 32'd0);
        end
        check("R1 reset pin", {31'd0, pwm_out}, 32'd0);

        // R2: staged readback, counter writes ignored
        bus_write(4'h4, 32'd7);
        bus_write(4'h8, 32'd3);
        bus_read("R2 period readback", 4'h4, v);  check("R2 period", v, 32'd7);
        bus_read("R2 duty readback", 4'h8, v);    check("R2 duty", v, 32'd3);
        bus_write(4'h0, 32'hABCD);
        bus_read("R2 R3 counter ignored", 4'h0, v); check("R2 counter stays 0", v, 32'd0);

        // R10: start with staged values, normal polarity
        bus_write(4'hC, 32'h0B);
        idle(10);
        count_high(7, h); check("R10 R5 duty share 3/7", 32'(h), 32'd3);
        // R4: consecutive reads step by one modulo period
        bus_read("R4 live count a", 4'h0, v);
        bus_read("R4 live count b", 4'h0, v2);
        check("R4 count step", v2, (v + 1) % 7);

        // R7: unlocked mid-period rewrite
        bus_write(4'h8, 32'd5);
        idle(9);
        count_high(7, h); check("R7 new duty 5/7", 32'(h), 32'd5);

        // R8: lock holds across staging
        bus_write(4'hC, 32'h4B);
        bus_write(4'h4, 32'd4);
        bus_write(4'h8, 32'd1);
        idle(20);
        count_high(7, h); check("R8 locked duty stays 5/7", 32'(h), 32'd5);
        bus_read("R8 R2 staged period", 4'h4, v); check("R8 staged period", v, 32'd4);

        // R9: unlock and invert in one write
        bus_write(4'hC, 32'h13);
        idle(8);
        count_high(8, h); check("R9 R5 inverted 1 low in 4", 32'(h), 32'd6);

        // R6: duty at/above period, zero duty, zero period
        bus_write(4'hC, 32'h0B);
        bus_write(4'h8, 32'd9);
        idle(8);
        count_high(8, h); check("R6 full duty", 32'(h), 32'd8);
        bus_write(4'h8, 32'd0);
        idle(8);
        count_high(8, h); check("R6 zero duty", 32'(h), 32'd0);
        bus_write(4'h4, 32'd0);
        bus_write(4'h8, 32'd5);
        idle(6);
        count_high(6, h); check("R6 zero period", 32'(h), 32'd0);
        bus_read("R6 zero period counter", 4'h0, v); check("R6 counter 0", v, 32'd0);

        // R3: enable alone or continuous alone stops the channel
        bus_write(4'h4, 32'd5);
        bus_write(4'hC, 32'h19);
        idle(4);
        check("R3 idle high pin", {31'd0, pwm_out}, 32'd1);
        bus_read("R3 counter stopped", 4'h0, v); check("R3 counter 0", v, 32'd0);
        bus_write(4'hC, 32'h02);
        idle(4);
        check("R3 idle low pin", {31'd0, pwm_out}, 32'd0);

        // R2: control readback mask
        bus_write(4'hC, 32'hFF);
        bus_read("R2 ctrl readback", 4'hC, v); check("R2 ctrl mask", v, 32'h5B);
        idle(12);

        finish_run();
    end

endmodule